// File: doc/BRIEF.md
# Multiplexed Host Register Bus Slave

This block gives a host controller access to a small bank of 8-bit registers. The host uses a parallel strobe interface: chip select, a phase line that picks address or data, and separate write and read strobes, all active low except the phase line. Eight shared lines carry both the register index and the data. Every access has two steps. A write with the phase line high stores an index. The next strobe with the phase line low reads or writes the register at that index. The block answers each strobe on an active-low ready line.

All host inputs are brought into the clock domain through a two-stage synchroniser, and the block acts on the falling edge of the synchronised strobe. The block holds two registers of its own: a fixed revision code and an interrupt controller. The interrupt controller watches two card-detect inputs and drives an active-low interrupt line. Every other mapped index is passed outward as a one-cycle write or read enable. Read data for those indices comes back on a flat input vector.

Top module: `hostbus_slave`

## Requirements
- R1: After reset `bus_rdy_n` and `irq_n` are 1, `bus_doe` is 0 and no bit of `reg_wen` or `reg_ren` is set.
- R2: A write strobe with `bus_addr_sel`=1 stores `bus_din` as the register index. A read strobe with `bus_addr_sel`=1 returns the stored index on `bus_dout`.
- R3: A write strobe with `bus_addr_sel`=0 to an outward index (0x01, 0x04 to 0x0A, 0x0C, 0x0D) raises bit [index] of `reg_wen` for exactly one cycle, with `reg_wdata` equal to the written byte.
- R4: A read strobe with `bus_addr_sel`=0 to an outward index returns byte [index] of `reg_rdata` (bits index*8+7 down to index*8) and raises bit [index] of `reg_ren` for one cycle.
- R5: Index 0x0F always reads the REVISION parameter (default 0x5A). Writes to it raise no enable and leave its value unchanged.
- R6: Indices 0x02, 0x03, 0x0B, 0x0E and any index of 0x10 or above read as 0x00, and no access to them raises any bit of `reg_wen` or `reg_ren`.
- R7: `bus_rdy_n` goes low on the third rising clock edge after a strobe falls while `bus_cs_n` is low. It goes high again on the third edge after both strobes are high. A strobe while `bus_cs_n` is high changes nothing and leaves `bus_rdy_n` high.
- R8: Writing 0x44 to index 0x00 enables interrupts, and any other value disables them and clears a pending interrupt. A read of index 0x00 returns bit 6 = enabled and bit 0 = pending, with all other bits 0.
- R9: While interrupts are enabled, any change on `card_det` sets the pending flag, and `irq_n` is the inverse of that flag. While they are disabled, changes on `card_det` have no effect.
- R10: A read of index 0x00 clears the pending flag. If a card-detect change is seen in the same cycle as that read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_addr_sel | input | 1 | 1 = index phase, 0 = data phase |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_din | input | 8 | Shared index/data lines, host to block |
| bus_dout | output | 8 | Read data to host |
| bus_doe | output | 1 | High while `bus_dout` should drive the shared lines |
| bus_rdy_n | output | 1 | Ready handshake, active low |
| card_det | input | 2 | Card-detect inputs that raise interrupts |
| irq_n | output | 1 | Interrupt request, active low |
| reg_wen | output | 16 | One-hot write enable per register index |
| reg_ren | output | 16 | One-hot read enable per register index |
| reg_wdata | output | 8 | Write data that goes with `reg_wen` |
| reg_rdata | input | 128 | Read data from outward registers, byte n for index n |

## Verification
Two events can land in the same cycle: the acknowledging read of the interrupt-control register and a card-detect change. Both pass through synchroniser stages of the same depth. The bench therefore toggles `card_det` on the same clock edge that it lowers the read strobe, so the interrupt controller sees both events together. It then checks three things: the read returns the pre-read status (0x40, enabled and not pending), `irq_n` is low afterwards, and a second read returns 0x41 and releases `irq_n`.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 16;
    localparam int CD_W    = 2;
    localparam int SYNC_W  = CD_W + DW + 4;
    localparam int IDX_IRQ = 0;
    localparam int IDX_REV = NREG - 1;
    localparam logic [DW-1:0] IRQ_ENABLE_CODE = 8'h44;

    typedef struct packed {
        logic [DW-1:0]   idx;
        logic [DW-1:0]   rdata;
        logic [DW-1:0]   wdata;
        logic [NREG-1:0] wen;
        logic [NREG-1:0] ren;
        logic            rdy_n;
        logic            oe;
        logic            prev_wr_n;
        logic            prev_rd_n;
        logic [CD_W-1:0] cd_prev;
    } hb_core_t;

    typedef struct packed {
        logic en;
        logic pend;
    } hb_irq_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int            W   = 4,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st1_d, st1_q, st2_d, st2_q;

    always_comb begin
        st1_d = din;
        st2_d = st1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= RST;
            st2_q <= RST;
        end else begin
            st1_q <= st1_d;
            st2_q <= st2_d;
        end
    end

    assign dout = st2_q;
endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic [DW-1:0]   idx,
    output logic [NREG-1:0] hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (idx == DW'(i));
    end
endmodule

// File: rtl/hb_irq.sv
module hb_irq
    import hb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic [DW-1:0] wdata,
    input  logic          cd_change,
    output logic          en,
    output logic          pend
);
    hb_irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ctl_wr) begin
            irq_d.en = (wdata == IRQ_ENABLE_CODE);
            if (wdata != IRQ_ENABLE_CODE) irq_d.pend = 1'b0;
        end
        if (ctl_rd) irq_d.pend = 1'b0;
        if (cd_change && irq_q.en && irq_d.en) irq_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign en   = irq_q.en;
    assign pend = irq_q.pend;

    // R9: a pending flag can only appear while enabled
    a_r9_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q.pend) |-> $past(irq_q.en));
    // R10: acknowledge without a simultaneous change clears the flag
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !cd_change) |=> !irq_q.pend);
    // R8: a disabling write leaves nothing pending
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata != IRQ_ENABLE_CODE) |=> (!irq_q.pend && !irq_q.en));
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hb_pkg::*;
#(
    parameter logic [DW-1:0]   REVISION = 8'h5A,
    parameter logic [NREG-1:0] EXT_MAP  = 16'h37F2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cs_n,
    input  logic               bus_addr_sel,
    input  logic               bus_wr_n,
    input  logic               bus_rd_n,
    input  logic [DW-1:0]      bus_din,
    output logic [DW-1:0]      bus_dout,
    output logic               bus_doe,
    output logic               bus_rdy_n,
    input  logic [CD_W-1:0]    card_det,
    output logic               irq_n,
    output logic [NREG-1:0]    reg_wen,
    output logic [NREG-1:0]    reg_ren,
    output logic [DW-1:0]      reg_wdata,
    input  logic [NREG*DW-1:0] reg_rdata
);
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CD_W{1'b0}}, {DW{1'b0}}, 4'b1101};

    logic [SYNC_W-1:0] sy;
    logic              s_cs_n, s_sel, s_wr_n, s_rd_n;
    logic [DW-1:0]     s_din;
    logic [CD_W-1:0]   s_cd;

    hb_sync #(.W(SYNC_W), .RST(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({card_det, bus_din, bus_rd_n, bus_wr_n, bus_addr_sel, bus_cs_n}),
        .dout (sy)
    );

    assign s_cs_n = sy[0];
    assign s_sel  = sy[1];
    assign s_wr_n = sy[2];
    assign s_rd_n = sy[3];
    assign s_din  = sy[4 +: DW];
    assign s_cd   = sy[4+DW +: CD_W];

    hb_core_t core_d, core_q;

    logic [NREG-1:0] hit, ext_hit;
    logic            wr_go, rd_go, released, data_wr, data_rd, cd_change;
    logic            irq_en, irq_pend;
    logic [DW-1:0]   ext_val, rd_val, irq_status;

    hb_decode u_dec (
        .idx(core_q.idx),
        .hit(hit)
    );

    assign ext_hit   = hit & EXT_MAP;
    assign wr_go     = core_q.prev_wr_n & ~s_wr_n & ~s_cs_n;
    assign rd_go     = core_q.prev_rd_n & ~s_rd_n & ~s_cs_n & ~wr_go;
    assign released  = s_wr_n & s_rd_n;
    assign data_wr   = wr_go & ~s_sel;
    assign data_rd   = rd_go & ~s_sel;
    assign cd_change = (s_cd != core_q.cd_prev);

    hb_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (data_wr & hit[IDX_IRQ]),
        .ctl_rd   (data_rd & hit[IDX_IRQ]),
        .wdata    (s_din),
        .cd_change(cd_change),
        .en       (irq_en),
        .pend     (irq_pend)
    );

    assign irq_status = {1'b0, irq_en, 5'b0_0000, irq_pend};

    always_comb begin
        ext_val = '0;
        for (int i = 0; i < NREG; i++) begin
            ext_val = ext_val | (reg_rdata[i*DW +: DW] & {DW{ext_hit[i]}});
        end
        rd_val = ext_val
               | (REVISION   & {DW{hit[IDX_REV]}})
               | (irq_status & {DW{hit[IDX_IRQ]}});
    end

    always_comb begin
        core_d           = core_q;
        core_d.wen       = '0;
        core_d.ren       = '0;
        core_d.prev_wr_n = s_wr_n;
        core_d.prev_rd_n = s_rd_n;
        core_d.cd_prev   = s_cd;
        if (wr_go) begin
            if (s_sel) begin
                core_d.idx = s_din;
            end else begin
                core_d.wen   = ext_hit;
                core_d.wdata = s_din;
            end
            core_d.rdy_n = 1'b0;
        end else if (rd_go) begin
            core_d.rdata = s_sel ? core_q.idx : rd_val;
            core_d.ren   = s_sel ? '0 : ext_hit;
            core_d.oe    = 1'b1;
            core_d.rdy_n = 1'b0;
        end else if (released) begin
            core_d.rdy_n = 1'b1;
            core_d.oe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q           <= '0;
            core_q.rdy_n     <= 1'b1;
            core_q.prev_wr_n <= 1'b1;
            core_q.prev_rd_n <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign bus_dout  = core_q.rdata;
    assign bus_doe   = core_q.oe;
    assign bus_rdy_n = core_q.rdy_n;
    assign reg_wen   = core_q.wen;
    assign reg_ren   = core_q.ren;
    assign reg_wdata = core_q.wdata;
    assign irq_n     = ~irq_pend;

    // R3: at most one register written per cycle
    a_r3_wen_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wen) && $onehot0(reg_ren));
    // R3: a write enable lasts one cycle
    a_r3_wen_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wen) |=> (reg_wen == '0));
    // R6: unmapped and internal indices never reach outward enables
    a_r6_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wen | reg_ren) & ~EXT_MAP) == '0);
    // R7: released strobes return ready high
    a_r7_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_n && s_rd_n) |=> bus_rdy_n);
    // R7: ready only answers a selected strobe
    a_r7_rdy_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdy_n) |-> $past(!s_cs_n));
endmodule

// File: tb/hostbus_slave_bench.sv
module hostbus_slave_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] REV = 8'h5A;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_cs_n = 1'b1, bus_addr_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [7:0]   bus_din = '0;
    logic [7:0]   bus_dout;
    logic         bus_doe, bus_rdy_n, irq_n;
    logic [1:0]   card_det = 2'b00;
    logic [15:0]  reg_wen, reg_ren;
    logic [7:0]   reg_wdata;
    logic [127:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int wcnt = 0, rcnt = 0;
    int widx = -1, ridx = -1;
    logic [7:0] wval = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_slave u_hostbus_slave (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_addr_sel(bus_addr_sel),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n), .card_det(card_det), .irq_n(irq_n),
        .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] ext_byte(int i);
        return 8'(i * 29 + 3);
    endfunction

    function automatic bit is_ext(int i);
        return (i == 1) || (i >= 4 && i <= 10) || (i == 12) || (i == 13);
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++) reg_rdata[i*8 +: 8] = ext_byte(i);
    end

    always @(negedge clk) begin
        if (|reg_wen) begin
            wcnt++;
            wval = reg_wdata;
            for (int i = 0; i < 16; i++) if (reg_wen[i]) widx = i;
        end
        if (|reg_ren) begin
            rcnt++;
            for (int i = 0; i < 16; i++) if (reg_ren[i]) ridx = i;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit sel, input logic [7:0] d,
                          output logic [7:0] rd, output logic rdy);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_addr_sel = sel; bus_din = d;
        if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        rd = bus_dout; rdy = bus_rdy_n;
        bus_wr_n = 1'b1; bus_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        logic [7:0] r; logic y;
        access(1'b1, 1'b1, idx, r, y);
        access(1'b1, 1'b0, d, r, y);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] r);
        logic y;
        access(1'b1, 1'b1, idx, r, y);
        access(1'b0, 1'b0, 8'h00, r, y);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       y;
        int         list [19];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bus_rdy_n == 1'b1, "R1 rdy_n", bus_rdy_n, 1);
        check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        check(bus_doe == 1'b0, "R1 doe", bus_doe, 0);
        check(reg_wen == '0 && reg_ren == '0, "R1 enables", reg_wen | reg_ren, 0);

        // R7 ready timing on one write strobe
        @(negedge clk);
        bus_cs_n = 1'b0; bus_addr_sel = 1'b1; bus_din = 8'h07; bus_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_rdy_n == 1'b1, "R7 ready not before third edge", bus_rdy_n, 1);
        @(negedge clk);
        check(bus_rdy_n == 1'b0, "R7 ready on third edge", bus_rdy_n, 0);
        bus_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_rdy_n == 1'b0, "R7 ready held until release seen", bus_rdy_n, 0);
        @(negedge clk);
        check(bus_rdy_n == 1'b1, "R7 ready released", bus_rdy_n, 1);
        bus_cs_n = 1'b1;

        // R7 strobe with chip select high is ignored
        @(negedge clk);
        bus_addr_sel = 1'b1; bus_din = 8'h0F; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_rdy_n == 1'b1, "R7 no ready without cs", bus_rdy_n, 1);
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b1, 8'h00, r, y);
        check(r == 8'h07, "R7 index kept when cs high", r, 8'h07);
        check(y == 1'b0, "R2 ready on index read", y, 0);

        // sweep of indices
        for (int k = 0; k < 16; k++) list[k] = k;
        list[16] = 16'h10; list[17] = 16'h80; list[18] = 16'hFF;
        foreach (list[k]) begin
            int i;
            logic [7:0] pat, exp;
            i = list[k];
            pat = 8'(i * 17) ^ 8'hA5;
            wcnt = 0; rcnt = 0; widx = -1; ridx = -1;
            access(1'b1, 1'b1, 8'(i), r, y);
            access(1'b0, 1'b1, 8'h00, r, y);
            check(r == 8'(i), "R2 index readback", r, i);
            access(1'b1, 1'b0, pat, r, y);
            if (is_ext(i)) begin
                check(wcnt == 1 && widx == i, "R3 write enable index", widx, i);
                check(wval == pat, "R3 write data", wval, pat);
            end else begin
                check(wcnt == 0, (i == 15) ? "R5 rev write ignored" : "R6 no write enable", wcnt, 0);
            end
            access(1'b0, 1'b0, 8'h00, r, y);
            if (is_ext(i)) exp = ext_byte(i);
            else if (i == 15) exp = REV;
            else exp = 8'h00;
            if (is_ext(i)) begin
                check(r == exp, "R4 outward read data", r, exp);
                check(rcnt == 1 && ridx == i, "R4 read enable index", ridx, i);
            end else if (i == 15) begin
                check(r == exp, "R5 revision value", r, exp);
            end else if (i == 0) begin
                check(r == exp, "R8 disabled status", r, exp);
            end else begin
                check(r == exp && rcnt == 0, "R6 unmapped reads zero", r, exp);
            end
        end

        // R8 enable and R9 event while enabled
        wr_reg(8'h00, 8'h44);
        rd_reg(8'h00, r);
        check(r == 8'h40, "R8 enabled status", r, 8'h40);
        check(irq_n == 1'b1, "R9 no irq before change", irq_n, 1);
        @(negedge clk); card_det = 2'b01;
        repeat (5) @(negedge clk);
        check(irq_n == 1'b0, "R9 irq after change", irq_n, 0);
        rd_reg(8'h00, r);
        check(r == 8'h41, "R8 pending status", r, 8'h41);
        check(irq_n == 1'b1, "R10 read clears", irq_n, 1);

        // R10 collision: card change in same cycle as acknowledge read
        access(1'b1, 1'b1, 8'h00, r, y);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_addr_sel = 1'b0; bus_rd_n = 1'b0; card_det = 2'b11;
        repeat (4) @(negedge clk);
        check(bus_dout == 8'h40, "R10 collision read value", bus_dout, 8'h40);
        check(irq_n == 1'b0, "R10 change wins over ack", irq_n, 0);
        bus_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_cs_n = 1'b1;
        rd_reg(8'h00, r);
        check(r == 8'h41, "R10 still pending", r, 8'h41);
        check(irq_n == 1'b1, "R10 second read clears", irq_n, 1);

        // R8 disable clears pending, R9 no effect while disabled
        @(negedge clk); card_det = 2'b10;
        repeat (5) @(negedge clk);
        check(irq_n == 1'b0, "R9 pending again", irq_n, 0);
        wr_reg(8'h00, 8'h04);
        check(irq_n == 1'b1, "R8 disable clears", irq_n, 1);
        @(negedge clk); card_det = 2'b01;
        repeat (5) @(negedge clk);
        check(irq_n == 1'b1, "R9 ignored while disabled", irq_n, 1);
        rd_reg(8'h00, r);
        check(r == 8'h00, "R8 status after disable", r, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule